// File: doc/BRIEF.md
# Redundant Output Compare Handshake

This block is the per-module controller for a small status handshake that lets a group of redundant processing modules agree on an output value before it is released. Each module drives one 3-bit status symbol and watches the symbols of its peers. A module configured as master presents its value, raises a compare request and waits for the peers marked as active slaves to answer. A module configured as slave compares the master's value with its own locally computed value, bit for bit, and answers agree or disagree.

A single timeout counter bounds every waiting phase, so a silent module is treated as disagreeing. The master grants a one-cycle output permit when at least one slave agrees, and marks each non-agreeing slave as faulty. If no slave agrees, the master marks itself faulty and stops taking part. Transport of the value itself, diagnostics and recovery are handled elsewhere.

The controller states are: IDLE (null, waiting for `start`), PRESENT (master, one cycle of null while the value is presented), REQUEST (master, compare held), CLOSE (master, null held until the slaves release), WAIT (slave, null until compare is seen) and ANSWER (slave, answer held). The transitions are: IDLE to PRESENT on `start` as a healthy master; IDLE to WAIT on `start` as a slave; PRESENT to REQUEST always; REQUEST to CLOSE when every active slave has answered or on timeout (the decision); CLOSE to IDLE when every active slave shows null or on timeout; WAIT to ANSWER on an accepted compare from the master or on timeout; ANSWER to IDLE when the master shows null or on timeout.

Top module: `outcmp_handshake`

## Requirements
- R1: The driven symbol uses 000 null, 011 agree, 110 disagree and 101 compare, and is null after reset; after reset `out_permit`, `self_fault` and `slave_fault` are 0.
- R2: As master, a `start` gives one cycle of null followed by compare, which is held until every peer set in `slave_mask` shows agree or disagree, or until TIMEOUT cycles have passed in REQUEST.
- R3: A peer symbol is used only after a two-flop synchronizer and after it has been stable on two consecutive clocks, so a one-cycle pulse is ignored; codes 001, 010, 100 and 111 count as disagree.
- R4: At the decision, if at least one active slave agrees, `out_permit` pulses for exactly one cycle, and in that cycle the driven symbol is already null.
- R5: When the permit is granted, each active slave that did not agree (disagree, illegal code or silent) gets its bit set in `slave_fault`, which stays set until reset.
- R6: If no active slave agrees at the decision, `self_fault` is set until reset, no permit is given, and later `start` requests in master mode are ignored (symbol stays null).
- R7: After the decision the master holds null until every active slave shows null or TIMEOUT cycles have passed; a `start` in that time is ignored.
- R8: As slave, a `start` gives null until the symbol of peer `master_idx` is accepted as compare; the next cycle it answers agree if `master_val` equals `local_val` in every bit, otherwise disagree.
- R9: As slave, if no compare is accepted within TIMEOUT cycles of waiting, the answer is disagree.
- R10: As slave, the answer is held until the master's accepted symbol is null or TIMEOUT cycles have passed, then null is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1: master role, 0: slave role |
| master_idx | input | IDX_W | Peer index of the master, used in slave role |
| slave_mask | input | NUM_PEERS | Peers acting as active slaves, used in master role |
| start | input | 1 | Master: value presented; slave: transfer expected |
| local_val | input | DATA_W | Value computed by this module |
| master_val | input | DATA_W | Value received from the master |
| peer_sym | input | 3*NUM_PEERS | Raw status symbols of the peers, peer i at bits 3i+2..3i |
| my_sym | output | 3 | Status symbol driven by this module |
| out_permit | output | 1 | One-cycle output release pulse |
| self_fault | output | 1 | Master saw no agreeing slave (sticky) |
| slave_fault | output | NUM_PEERS | Slaves that failed to agree with a granted output (sticky) |

## Verification
The master function is driven with all slaves agreeing, one slave silent until the timeout, one disagreeing, one sending an illegal code, a one-cycle glitch before a real answer, and a lone disagreeing slave; these separate the permit, the per-slave fault marking, the input filter and the self-fault path. The slave function is driven with equal values, values one bit apart, a master that never requests, and a master that never releases, which separate the bit-exact compare from both timeout exits. A `start` during the closing phase and after a self-fault shows that those requests have no effect on the driven symbol.

// File: rtl/outcmp_pkg.sv
package outcmp_pkg;
    localparam int SYM_W = 3;
    localparam logic [SYM_W-1:0] SYM_NULL     = 3'b000;
    localparam logic [SYM_W-1:0] SYM_AGREE    = 3'b011;
    localparam logic [SYM_W-1:0] SYM_DISAGREE = 3'b110;
    localparam logic [SYM_W-1:0] SYM_COMPARE  = 3'b101;

    typedef enum logic [1:0] {
        CL_NULL, CL_AGREE, CL_DISAGREE, CL_COMPARE
    } sym_class_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRESENT, ST_REQUEST, ST_CLOSE, ST_WAIT, ST_ANSWER
    } hs_state_t;
endpackage

// File: rtl/outcmp_sym_rx.sv
module outcmp_sym_rx
    import outcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] sym_in,
    output sym_class_t       cls_out
);
    logic [SYM_W-1:0] sync1_q, sync2_q, hold_q, accepted_q;

    // two-flop synchronizer, then a two-clock stability filter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q    <= SYM_NULL;
            sync2_q    <= SYM_NULL;
            hold_q     <= SYM_NULL;
            accepted_q <= SYM_NULL;
        end else begin
            sync1_q <= sym_in;
            sync2_q <= sync1_q;
            hold_q  <= sync2_q;
            if (sync2_q == hold_q)
                accepted_q <= sync2_q;
        end
    end

    always_comb begin
        unique case (accepted_q)
            SYM_NULL:    cls_out = CL_NULL;
            SYM_AGREE:   cls_out = CL_AGREE;
            SYM_COMPARE: cls_out = CL_COMPARE;
            default:     cls_out = CL_DISAGREE;
        endcase
    end
endmodule

// File: rtl/outcmp_timer.sv
module outcmp_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/outcmp_handshake.sv
module outcmp_handshake
    import outcmp_pkg::*;
#(
    parameter int NUM_PEERS = 3,
    parameter int DATA_W    = 8,
    parameter int TIMEOUT   = 16,
    parameter int IDX_W     = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       is_master,
    input  logic [IDX_W-1:0]           master_idx,
    input  logic [NUM_PEERS-1:0]       slave_mask,
    input  logic                       start,
    input  logic [DATA_W-1:0]          local_val,
    input  logic [DATA_W-1:0]          master_val,
    input  logic [SYM_W*NUM_PEERS-1:0] peer_sym,
    output logic [SYM_W-1:0]           my_sym,
    output logic                       out_permit,
    output logic                       self_fault,
    output logic [NUM_PEERS-1:0]       slave_fault
);
    sym_class_t           peer_cls [NUM_PEERS];
    sym_class_t           master_cls;
    logic [NUM_PEERS-1:0] agree_v, answered_v, null_v, agree_m;
    logic                 all_answered, all_null, vals_match;
    logic                 tmr_restart, tmr_expired, decide, slave_resolve;
    hs_state_t            state_q, state_d;
    logic [SYM_W-1:0]     answer_q;

    generate
        for (genvar g = 0; g < NUM_PEERS; g++) begin : g_rx
            outcmp_sym_rx u_rx (
                .clk     (clk),
                .rst_n   (rst_n),
                .sym_in  (peer_sym[g*SYM_W +: SYM_W]),
                .cls_out (peer_cls[g])
            );
        end
    endgenerate

    always_comb begin
        master_cls = CL_NULL;
        for (int i = 0; i < NUM_PEERS; i++) begin
            agree_v[i]    = (peer_cls[i] == CL_AGREE);
            answered_v[i] = (peer_cls[i] == CL_AGREE) || (peer_cls[i] == CL_DISAGREE);
            null_v[i]     = (peer_cls[i] == CL_NULL);
            if (int'(master_idx) == i)
                master_cls = peer_cls[i];
        end
    end

    assign agree_m       = agree_v & slave_mask;
    assign all_answered  = &(answered_v | ~slave_mask);
    assign all_null      = &(null_v | ~slave_mask);
    assign vals_match    = (master_val == local_val);
    assign decide        = (state_q == ST_REQUEST) && (all_answered || tmr_expired);
    assign slave_resolve = (state_q == ST_WAIT) && ((master_cls == CL_COMPARE) || tmr_expired);
    assign tmr_restart   = (state_d != state_q);

    outcmp_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .expired (tmr_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (start) begin
                    if (!is_master)      state_d = ST_WAIT;
                    else if (!self_fault) state_d = ST_PRESENT;
                end
            ST_PRESENT: state_d = ST_REQUEST;
            ST_REQUEST: if (decide) state_d = ST_CLOSE;
            ST_CLOSE:   if (all_null || tmr_expired) state_d = ST_IDLE;
            ST_WAIT:    if (slave_resolve) state_d = ST_ANSWER;
            ST_ANSWER:  if ((master_cls == CL_NULL) || tmr_expired) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // registered outputs and answer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_permit  <= 1'b0;
            self_fault  <= 1'b0;
            slave_fault <= '0;
            answer_q    <= SYM_NULL;
        end else begin
            out_permit <= 1'b0;
            if (decide) begin
                if (|agree_m) begin
                    out_permit  <= 1'b1;
                    slave_fault <= slave_fault | (slave_mask & ~agree_m);
                end else begin
                    self_fault <= 1'b1;
                end
            end
            if (slave_resolve)
                answer_q <= ((master_cls == CL_COMPARE) && vals_match) ? SYM_AGREE : SYM_DISAGREE;
        end
    end

    // symbol decode
    always_comb begin
        unique case (state_q)
            ST_REQUEST: my_sym = SYM_COMPARE;
            ST_ANSWER:  my_sym = answer_q;
            default:    my_sym = SYM_NULL;
        endcase
    end
endmodule

// File: rtl/outcmp_handshake_sva.sv
module outcmp_handshake_sva
    import outcmp_pkg::*;
#(
    parameter int NUM_PEERS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SYM_W-1:0]     my_sym,
    input logic                 out_permit,
    input logic                 self_fault,
    input logic [NUM_PEERS-1:0] slave_fault
);
    // R1: only the four legal codes are ever driven
    p_legal_symbol_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (my_sym == SYM_NULL) || (my_sym == SYM_AGREE) ||
        (my_sym == SYM_DISAGREE) || (my_sym == SYM_COMPARE));

    // R4: permit is a single-cycle pulse
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_permit |=> !out_permit);

    // R4: symbol back to null while the permit is shown
    p_null_on_permit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_permit |-> (my_sym == SYM_NULL));

    // R5: slave fault bits never clear
    p_slave_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|slave_fault) |=> ((slave_fault & $past(slave_fault)) == $past(slave_fault)));

    // R6: self fault stays set and blocks the permit
    p_self_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        self_fault |=> self_fault);

    p_no_permit_faulty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        self_fault |-> !out_permit);

    // R6: symbol is null when the self fault appears
    p_null_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_fault) |-> (my_sym == SYM_NULL));
endmodule

bind outcmp_handshake outcmp_handshake_sva #(.NUM_PEERS(NUM_PEERS)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .my_sym      (my_sym),
    .out_permit  (out_permit),
    .self_fault  (self_fault),
    .slave_fault (slave_fault)
);

// File: tb/outcmp_handshake_test.sv
module outcmp_handshake_test;
    localparam int NP  = 3;
    localparam int DW  = 8;
    localparam int TMO = 24;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, is_master, start;
    logic [1:0]    master_idx;
    logic [NP-1:0] slave_mask;
    logic [DW-1:0] local_val, master_val;
    logic [3*NP-1:0] peer_sym;
    logic [2:0]    my_sym;
    logic          out_permit, self_fault;
    logic [NP-1:0] slave_fault;

    outcmp_handshake #(.NUM_PEERS(NP), .DATA_W(DW), .TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .master_idx(master_idx),
        .slave_mask(slave_mask), .start(start), .local_val(local_val),
        .master_val(master_val), .peer_sym(peer_sym), .my_sym(my_sym),
        .out_permit(out_permit), .self_fault(self_fault), .slave_fault(slave_fault)
    );

    int checks = 0, errors = 0;
    string tag = "R1";

    // reference model: phases 0 idle,1 present,2 request,3 close,4 wait,5 answer
    int ph = 0, tk = 0, m_ans = 0, m_sf = 0;
    bit m_perm = 0, m_self = 0;
    int acc [NP];
    int hq  [NP][$];

    function automatic int kind(int v);  // 0 null,1 agree,2 disagree,3 compare
        if (v == 0) return 0;
        if (v == 3) return 1;
        if (v == 5) return 3;
        return 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; tk = 0; m_ans = 0; m_sf = 0; m_perm = 0; m_self = 0;
            for (int i = 0; i < NP; i++) begin
                acc[i] = 0;
                hq[i]  = {0, 0, 0};
            end
        end else begin
            int nph, agr, mk;
            bit exp_t, ans_all, nul_all;
            nph = ph; m_perm = 0; exp_t = (tk == TMO - 1);
            agr = 0; ans_all = 1; nul_all = 1;
            for (int i = 0; i < NP; i++) if (slave_mask[i]) begin
                if (kind(acc[i]) == 1) agr |= (1 << i);
                if (kind(acc[i]) != 1 && kind(acc[i]) != 2) ans_all = 0;
                if (kind(acc[i]) != 0) nul_all = 0;
            end
            mk = (int'(master_idx) < NP) ? kind(acc[master_idx]) : 0;
            case (ph)
                0: if (start) nph = !is_master ? 4 : (m_self ? 0 : 1);
                1: nph = 2;
                2: if (ans_all || exp_t) begin
                       nph = 3;
                       if (agr != 0) begin m_perm = 1; m_sf |= (int'(slave_mask) & ~agr); end
                       else m_self = 1;
                   end
                3: if (nul_all || exp_t) nph = 0;
                4: if (mk == 3) begin m_ans = (master_val == local_val) ? 3 : 6; nph = 5; end
                   else if (exp_t) begin m_ans = 6; nph = 5; end
                5: if (mk == 0 || exp_t) nph = 0;
                default: nph = 0;
            endcase
            tk = (nph != ph) ? 0 : (exp_t ? tk : tk + 1);
            ph = nph;
            for (int i = 0; i < NP; i++) begin
                // hq[i]: [0]=oldest of three previous samples
                if (hq[i][1] == hq[i][0]) acc[i] = hq[i][1];
                void'(hq[i].pop_front());
                hq[i].push_back(int'(peer_sym[3*i +: 3]));
            end
        end
    end

    task automatic chk(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", t, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) if (rst_n) begin
        int es;
        es = (ph == 2) ? 5 : ((ph == 5) ? m_ans : 0);
        chk({tag, " sym"}, int'(my_sym), es);
        chk({tag, " permit"}, int'(out_permit), int'(m_perm));
        chk({tag, " self_fault"}, int'(self_fault), int'(m_self));
        chk({tag, " slave_fault"}, int'(slave_fault), m_sf);
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_peer(int i, logic [2:0] c);
        peer_sym[3*i +: 3] = c;
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(1); start = 1'b0;
    endtask

    task automatic wait_sym(string t, int code);
        int n = 0;
        while (int'(my_sym) != code && n < 200) begin tick(1); n++; end
        chk({t, " wait symbol"}, int'(my_sym), code);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        tick(150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 0; is_master = 1; start = 0; master_idx = 1; slave_mask = '0;
        local_val = '0; master_val = '0; peer_sym = '0;
        tick(4); rst_n = 1; tick(1);
        tag = "R1";
        chk("R1 reset sym", int'(my_sym), 0);
        chk("R1 reset permit", int'(out_permit), 0);
        chk("R1 reset faults", int'({self_fault, slave_fault}), 0);

        // master, both slaves agree
        tag = "R2"; slave_mask = 3'b011; pulse_start();
        chk("R2 present is null", int'(my_sym), 0);
        wait_sym("R2", 5); tick(3);
        chk("R2 compare held", int'(my_sym), 5);
        set_peer(0, 3'b011); set_peer(1, 3'b011);
        tag = "R4"; wait_sym("R4", 0);
        chk("R4 permit pulse", int'(out_permit), 1);
        tick(1);
        chk("R4 single pulse", int'(out_permit), 0);
        tag = "R7"; pulse_start(); tick(4);
        chk("R7 start ignored while closing", int'(my_sym), 0);
        set_peer(0, 0); set_peer(1, 0); tick(TMO + 4);
        chk("R7 idle after close", int'(my_sym), 0);

        // glitch then real agree
        tag = "R3"; slave_mask = 3'b001; pulse_start(); wait_sym("R3", 5);
        set_peer(0, 3'b011); tick(1); set_peer(0, 0); tick(6);
        chk("R3 glitch ignored", int'(my_sym), 5);
        set_peer(0, 3'b011); wait_sym("R3", 0);
        chk("R3 permit after stable agree", int'(out_permit), 1);
        set_peer(0, 0); tick(8);

        // silent slave
        tag = "R5"; slave_mask = 3'b011; pulse_start(); wait_sym("R2", 5);
        set_peer(0, 3'b011); tick(TMO - 8);
        chk("R2 compare held for silent slave", int'(my_sym), 5);
        wait_sym("R5", 0);
        chk("R5 permit with silent slave", int'(out_permit), 1);
        chk("R5 silent slave flagged", int'(slave_fault), 3'b010);
        set_peer(0, 0); tick(8);

        // disagreeing slave
        slave_mask = 3'b101; pulse_start(); wait_sym("R5", 5);
        set_peer(2, 3'b011); set_peer(0, 3'b110); wait_sym("R5", 0);
        chk("R5 permit with one agree", int'(out_permit), 1);
        chk("R5 disagreeing slave flagged", int'(slave_fault), 3'b011);
        set_peer(0, 0); set_peer(2, 0); tick(8);

        // illegal code from a slave
        tag = "R3"; slave_mask = 3'b110; pulse_start(); wait_sym("R3", 5);
        set_peer(1, 3'b011); set_peer(2, 3'b111); wait_sym("R3", 0);
        chk("R3 illegal code as disagree", int'(slave_fault), 3'b111);
        set_peer(1, 0); set_peer(2, 0); tick(8);

        // slave role
        is_master = 0; master_idx = 1; local_val = 8'hA5; master_val = 8'hA5;
        tag = "R8"; pulse_start(); tick(3);
        chk("R8 waiting is null", int'(my_sym), 0);
        set_peer(1, 3'b101); wait_sym("R8", 3);
        tag = "R10"; tick(3);
        chk("R10 answer held", int'(my_sym), 3);
        set_peer(1, 0); wait_sym("R10", 0); tick(4);

        tag = "R8"; master_val = 8'hA4; pulse_start();
        set_peer(1, 3'b101); wait_sym("R8", 6);
        chk("R8 one-bit difference disagrees", int'(my_sym), 6);
        set_peer(1, 0); wait_sym("R8", 0); tick(4);

        tag = "R9"; master_val = 8'hA5; pulse_start(); tick(TMO - 4);
        chk("R9 still waiting", int'(my_sym), 0);
        wait_sym("R9", 6); tick(3);
        chk("R9 released after timeout", int'(my_sym), 0);

        tag = "R10"; pulse_start(); set_peer(1, 3'b101); wait_sym("R10", 3);
        tick(TMO + 2);
        chk("R10 answer timed out", int'(my_sym), 0);
        set_peer(1, 0); tick(8);

        // master with no agreeing slave
        is_master = 1; tag = "R6"; slave_mask = 3'b001; pulse_start();
        wait_sym("R6", 5); set_peer(0, 3'b110); wait_sym("R6", 0);
        chk("R6 self fault set", int'(self_fault), 1);
        chk("R6 no permit", int'(out_permit), 0);
        set_peer(0, 0); tick(TMO + 4); pulse_start(); tick(5);
        chk("R6 start ignored when faulty", int'(my_sym), 0);
        chk("R6 self fault kept", int'(self_fault), 1);
        tick(4);
        summary();
    end
endmodule